// File: doc/BRIEF.md
# SAR Conversion Phase Sequencer

This block is the timing controller for one successive-approximation conversion. A start strobe launches the conversion. The sequencer first holds a sampling window. Its length comes from a 2-bit field that arrives with the start strobe. After the window it can insert one or two gain-doubling steps, during which the comparator is not consulted. It then walks twelve comparison cycles from the most significant bit downward and builds the result from the comparator answers. A one-clock done pulse closes the conversion.

The analog side sees one strobe per phase: sample, gain or compare. The bit index tells the digital-to-analog stage which trial weight applies. The result register holds the finished code until the next conversion begins. It shows the partial code while comparisons run.

Top module: `sar_phase_seq`

## Requirements
- R1: After a synchronous active-high reset, the sequencer is idle. All three phase strobes, busy and done are low.
- R2: The sample strobe stays high for exactly 2, 8, 64 or 128 consecutive cycles for sample-time field values 0, 1, 2 and 3. The field is captured on the accepted start strobe, and later changes to it have no effect.
- R3: The gain strobe stays high for exactly 0, 1, 2 and 0 cycles for pre-gain settings 0 (1x), 1 (2x), 2 (4x) and 3 (reserved, treated as 1x). These cycles start only after the last sample cycle, and the compare strobe is low during them. The setting is captured with the start strobe.
- R4: The compare strobe stays high for exactly 12 consecutive cycles. The bit index output counts 11 down to 0, one step per cycle.
- R5: In the compare cycle with index k, result bit k becomes 1 if the comparator input is 1 and 0 otherwise. Bits below k read 0 until they are decided. The final result is therefore the binary-search code for the comparator.
- R6: Busy goes high on the clock edge that accepts a start and stays high until done. Done is high for exactly one cycle, the cycle after the last compare cycle, and busy is low in that cycle.
- R7: A start strobe while busy is high is ignored. The phase lengths and the result of the running conversion do not change.
- R8: While the sequencer is idle, the result output stays unchanged until a new start is accepted.
- R9: At most one of the sample, gain and compare strobes is high in any cycle. All of them are low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion start strobe |
| smp_sel_i | input | 2 | Sample window select, captured with start |
| gain_sel_i | input | 2 | Pre-gain setting, captured with start |
| comp_i | input | 1 | Comparator decision for the current trial bit |
| busy_o | output | 1 | Conversion in progress |
| samp_o | output | 1 | Sampling phase strobe |
| gain_o | output | 1 | Gain-doubling phase strobe |
| cmp_o | output | 1 | Compare phase strobe |
| bit_o | output | 4 | Current trial bit index |
| result_o | output | 12 | Conversion result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is the transition from the last sampling cycle into a gain step, or straight into comparison. It must happen at the same boundary for all 16 combinations of window length and pre-gain. The check also has to show that a stray start, or a change on the select inputs at that point, does not disturb it. The bench sweeps every combination with several target codes. For each target it emulates a comparator from the bit index and partial result, so the final code is known arithmetically. It changes both select inputs right after the start, and on alternate runs it pulses start again in the middle of sampling.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_GAIN   = 2'd2,
        PH_CONV   = 2'd3
    } phase_e;

    // number of compare-free doubling steps for a pre-gain setting
    function automatic logic [1:0] gain_steps(input logic [1:0] cfg);
        case (cfg)
            2'd1:    gain_steps = 2'd1;
            2'd2:    gain_steps = 2'd2;
            default: gain_steps = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/sar_win_counter.sv
module sar_win_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
    parameter int RES_W = 12,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             en_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             keep_i,
    output logic [RES_W-1:0] result_o
);
    logic [RES_W-1:0] res_d, res_q;

    always_comb begin
        res_d = res_q;
        if (clear_i) begin
            res_d = '0;
        end else if (en_i) begin
            for (int i = 0; i < RES_W; i++) begin
                if (idx_i == IDX_W'(i)) res_d[i] = keep_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign result_o = res_q;
endmodule

// File: rtl/sar_phase_seq.sv
module sar_phase_seq
    import sar_seq_pkg::*;
#(
    parameter int RES_W     = 12,
    parameter int SMP_LEN_0 = 2,
    parameter int SMP_LEN_1 = 8,
    parameter int SMP_LEN_2 = 64,
    parameter int SMP_LEN_3 = 128,
    localparam int IDX_W    = $clog2(RES_W),
    localparam int MAX_LEN  = (SMP_LEN_3 > RES_W) ? SMP_LEN_3 : RES_W,
    localparam int CNT_W    = $clog2(MAX_LEN) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [1:0]       smp_sel_i,
    input  logic [1:0]       gain_sel_i,
    input  logic             comp_i,
    output logic             busy_o,
    output logic             samp_o,
    output logic             gain_o,
    output logic             cmp_o,
    output logic [IDX_W-1:0] bit_o,
    output logic [RES_W-1:0] result_o,
    output logic             done_o
);
    typedef struct packed {
        phase_e     phase;
        logic [1:0] gain_cfg;
        logic       done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;
    logic             res_clear;
    logic             res_en;

    function automatic logic [CNT_W-1:0] smp_last(input logic [1:0] sel);
        case (sel)
            2'd0:    smp_last = CNT_W'(SMP_LEN_0 - 1);
            2'd1:    smp_last = CNT_W'(SMP_LEN_1 - 1);
            2'd2:    smp_last = CNT_W'(SMP_LEN_2 - 1);
            default: smp_last = CNT_W'(SMP_LEN_3 - 1);
        endcase
    endfunction

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        cnt_load   = 1'b0;
        cnt_val    = '0;
        res_clear  = 1'b0;
        res_en     = 1'b0;
        case (seq_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    seq_d.phase    = PH_SAMPLE;
                    seq_d.gain_cfg = gain_sel_i;
                    cnt_load       = 1'b1;
                    cnt_val        = smp_last(smp_sel_i);
                end
            end
            PH_SAMPLE: begin
                if (cnt_zero) begin
                    cnt_load = 1'b1;
                    if (gain_steps(seq_q.gain_cfg) != 2'd0) begin
                        seq_d.phase = PH_GAIN;
                        cnt_val     = CNT_W'(gain_steps(seq_q.gain_cfg) - 2'd1);
                    end else begin
                        seq_d.phase = PH_CONV;
                        cnt_val     = CNT_W'(RES_W - 1);
                        res_clear   = 1'b1;
                    end
                end
            end
            PH_GAIN: begin
                if (cnt_zero) begin
                    seq_d.phase = PH_CONV;
                    cnt_load    = 1'b1;
                    cnt_val     = CNT_W'(RES_W - 1);
                    res_clear   = 1'b1;
                end
            end
            default: begin
                res_en = 1'b1;
                if (cnt_zero) begin
                    seq_d.phase = PH_IDLE;
                    seq_d.done  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.phase    <= PH_IDLE;
            seq_q.gain_cfg <= 2'd0;
            seq_q.done     <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    sar_win_counter #(.CNT_W(CNT_W)) u_win (
        .clk        (clk),
        .rst        (rst),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .cnt_o      (cnt),
        .zero_o     (cnt_zero)
    );

    sar_approx_reg #(.RES_W(RES_W), .IDX_W(IDX_W)) u_sar (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (res_clear),
        .en_i     (res_en),
        .idx_i    (cnt[IDX_W-1:0]),
        .keep_i   (comp_i),
        .result_o (result_o)
    );

    assign busy_o = (seq_q.phase != PH_IDLE);
    assign samp_o = (seq_q.phase == PH_SAMPLE);
    assign gain_o = (seq_q.phase == PH_GAIN);
    assign cmp_o  = (seq_q.phase == PH_CONV);
    assign bit_o  = cmp_o ? cnt[IDX_W-1:0] : '0;
    assign done_o = seq_q.done;
endmodule

// File: rtl/sar_phase_seq_chk.sv
module sar_phase_seq_chk #(
    parameter int RES_W = 12,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             busy_o,
    input logic             samp_o,
    input logic             gain_o,
    input logic             cmp_o,
    input logic [IDX_W-1:0] bit_o,
    input logic [RES_W-1:0] result_o,
    input logic             done_o
);
    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({samp_o, gain_o, cmp_o}));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !(samp_o || gain_o || cmp_o));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R4
    bit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_o && !$rose(cmp_o)) |-> (bit_o == $past(bit_o) - 1'b1));

    // R4
    bit_top_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cmp_o) |-> (bit_o == IDX_W'(RES_W - 1)));

    // R3
    gain_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gain_o) |-> $past(samp_o));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(result_o));
endmodule

bind sar_phase_seq sar_phase_seq_chk #(.RES_W(RES_W), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .samp_o   (samp_o),
    .gain_o   (gain_o),
    .cmp_o    (cmp_o),
    .bit_o    (bit_o),
    .result_o (result_o),
    .done_o   (done_o)
);

// File: tb/test_sar_phase_seq.sv
module test_sar_phase_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  smp_sel_i = 2'd0;
    logic [1:0]  gain_sel_i = 2'd0;
    logic        comp_i;
    logic        busy_o, samp_o, gain_o, cmp_o, done_o;
    logic [3:0]  bit_o;
    logic [11:0] result_o;
    logic [11:0] target = 12'd0;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    // comparator model: keep the trial bit when trial code <= target
    assign comp_i = ((result_o | (12'd1 << bit_o)) <= target);

    sar_phase_seq i_sar_phase_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .smp_sel_i(smp_sel_i),
        .gain_sel_i(gain_sel_i), .comp_i(comp_i), .busy_o(busy_o),
        .samp_o(samp_o), .gain_o(gain_o), .cmp_o(cmp_o), .bit_o(bit_o),
        .result_o(result_o), .done_o(done_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int smp_len(input int s);
        return (s == 0) ? 2 : (s == 1) ? 8 : (s == 2) ? 64 : 128;
    endfunction

    function automatic int gain_len(input int g);
        return (g == 1) ? 1 : (g == 2) ? 2 : 0;
    endfunction

    task automatic run_conv(input int s, input int g, input int v, input bit poke);
        int n_s = 0, n_g = 0, n_c = 0, bad_bit = 0, bad_order = 0, cyc = 0;
        logic [11:0] held;
        target = v[11:0];
        @(negedge clk);
        start_i = 1'b1; smp_sel_i = s[1:0]; gain_sel_i = g[1:0];
        @(negedge clk);
        start_i = 1'b0;
        smp_sel_i = ~s[1:0]; gain_sel_i = ~g[1:0];  // R2 R3: capture only at start
        check("R6 busy after start", int'(busy_o), 1);
        while (!done_o && cyc < 400) begin
            if (samp_o) begin
                n_s++;
                if (n_g != 0 || n_c != 0) bad_order++;
                if (poke && n_s == 2) start_i = 1'b1;  // R7 stray start
                else start_i = 1'b0;
            end else start_i = 1'b0;
            if (gain_o) begin
                n_g++;
                if (n_c != 0) bad_order++;
            end
            if (cmp_o) begin
                if (int'(bit_o) != 11 - n_c) bad_bit++;
                n_c++;
            end
            if (!busy_o) bad_order++;
            cyc++;
            @(negedge clk);
        end
        start_i = 1'b0;
        if (cyc >= 400) check("R6 done timeout", 0, 1);
        check($sformatf("R2 sample len s=%0d poke=%0d", s, poke), n_s, smp_len(s));
        check($sformatf("R3 gain len g=%0d", g), n_g, gain_len(g));
        check("R3 phase order", bad_order, 0);
        check("R4 compare cycles", n_c, 12);
        check("R4 bit index order", bad_bit, 0);
        check($sformatf("R5 result v=%0d", v), int'(result_o), v);
        check("R6 busy low at done", int'(busy_o), 0);
        if (poke) check("R7 stray start ignored", n_s + n_g + n_c, smp_len(s) + gain_len(g) + 12);
        held = result_o;
        @(negedge clk);
        check("R6 done one cycle", int'(done_o), 0);
        target = ~target;
        repeat (3) @(negedge clk);
        check("R8 result held while idle", int'(result_o), int'(held));
        check("R9 strobes low idle", int'({samp_o, gain_o, cmp_o}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy reset", int'(busy_o), 0);
        check("R1 strobes reset", int'({samp_o, gain_o, cmp_o}), 0);
        check("R1 done reset", int'(done_o), 0);
        rst = 1'b0;
        @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            for (int g = 0; g < 4; g++) begin
                for (int k = 0; k < 6; k++) begin
                    int v;
                    case (k)
                        0: v = 0;
                        1: v = 4095;
                        2: v = 2048;
                        3: v = 2047;
                        4: v = 1;
                        default: v = (s * 1000 + g * 377 + 5) % 4096;
                    endcase
                    run_conv(s, g, v, k[0]);
                end
            end
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule